// File: doc/BRIEF.md
# Two-Wire Memory Read Slave

This block is the serial front end of a byte-wide memory that sits on a two-wire I2C bus. It samples the clock and data lines in the system clock domain and finds START and STOP conditions. It answers one 7-bit device address. It keeps a persistent address counter, which it presents to a synchronous memory read port.

A master loads the counter with a header: a write-addressed device byte followed by two word address bytes. After that header the master may send a repeated START with a read-addressed device byte, and data then streams from the loaded location. The master may instead end the header with STOP. The counter then holds the new location, and the next plain read begins there. Each byte the slave shifts out advances the counter by one, and the counter wraps at the end of the array. The master keeps a read going by acknowledging each byte, and ends it with a NACK or with a STOP in the acknowledge clock.

The data line is modelled as open drain. The block only ever pulls SDA low, and it does so only in its own acknowledge slots and in read data bits.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset, SDA is released and the address counter is 0, so a read issued before any header returns the byte at location 0.
- R2: START is a falling SDA edge while SCL is high, and STOP is a rising SDA edge while SCL is high. After a STOP, an unmatched device byte or a master NACK, the block never pulls SDA low until a new START arrives.
- R3: The device byte after a START is acknowledged only when its upper seven bits equal DEV_ADDR (default 7'h57, that is 8'hAE for a write and 8'hAF for a read; bit 0 is 1 for a read). Any other device byte gets no acknowledge.
- R4: After a matched write device byte, two word address bytes follow, the high byte first, and each one is acknowledged. Only the low log2(DEPTH) bits of the 16-bit value are kept (default DEPTH 512, so 9 bits).
- R5: A repeated START followed by a matched read byte after the second word address byte returns the byte stored at the loaded location first.
- R6: A STOP after the second word address byte transfers no data. It leaves the counter, which is visible on mem_addr, at the loaded location, and the next current-address read starts there.
- R7: A current-address read returns the byte at the counter. The counter advances by one for every byte shifted out, including the last byte of a read.
- R8: When the master acknowledges a byte, the slave sends the byte at the next location, and location DEPTH-1 is followed by location 0.
- R9: A NACK in the ninth clock ends the read. A STOP inside the ninth clock also ends the read. After either, further clocks read back as all ones.
- R10: Read data is sent MSB first, and a 0 bit pulls SDA low. sda_oe changes only while SCL is low, never during an SCL high phase.
- R11: mem_addr always shows the counter. mem_rdata is taken as the content of that location one system clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_o | output | 1 | Data output value, always 0 (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_addr | output | $clog2(DEPTH) | Read address to the memory array |
| mem_rdata | input | 8 | Memory data, valid one clock after mem_addr |

## Verification
A wrong phase state shows on the bus within one bit time. It appears as a missing or misplaced acknowledge, as a data bit driven in the wrong slot, or as SDA moving while SCL is high. A wrong address counter stays invisible until the next byte is read, possibly in a later transaction. For that reason the bench keeps its own model of the counter across transactions and compares every returned byte with it. Set-address headers, wrap at the array end and reads ended by NACK are interleaved so that a counter error carries into later checks, and mem_addr is read directly after header-only transfers.

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
  parameter int DEPTH = 512,
  parameter logic [6:0] DEV_ADDR = 7'h57
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe,
  output logic [$clog2(DEPTH)-1:0] mem_addr,
  input  logic [7:0] mem_rdata
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACKA, S_HI, S_ACKH, S_LO, S_ACKL, S_HOLD, S_RD, S_RACK
  } state_t;

  state_t st;
  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] rx, tx, hi;
  logic rd, mack;
  logic [AW-1:0] ptr;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= 4'd0;
      rx   <= 8'd0;
      tx   <= 8'hFF;
      hi   <= 8'd0;
      rd   <= 1'b0;
      mack <= 1'b0;
      ptr  <= '0;
    end else if (start_det) begin
      st  <= S_ADDR;
      cnt <= 4'd0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_ADDR, S_HI, S_LO: begin
          if (rise && cnt != 4'd8) begin
            rx  <= {rx[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            cnt <= 4'd0;
            if (st == S_ADDR) begin
              if (rx[7:1] == DEV_ADDR) begin
                st <= S_ACKA;
                rd <= rx[0];
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_HI) begin
              hi <= rx;
              st <= S_ACKH;
            end else begin
              ptr <= AW'({hi, rx});
              st  <= S_ACKL;
            end
          end
        end
        S_ACKA: if (fall) begin
          if (rd) begin
            tx  <= mem_rdata;
            cnt <= 4'd0;
            st  <= S_RD;
          end else begin
            st <= S_HI;
          end
        end
        S_ACKH: if (fall) st <= S_LO;
        S_ACKL: if (fall) st <= S_HOLD;
        S_RD: if (fall) begin
          if (cnt == 4'd7) begin
            st  <= S_RACK;
            ptr <= ptr + 1'b1;
          end else begin
            tx  <= {tx[6:0], 1'b0};
            cnt <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (rise) begin
            mack <= ~sda_s;
          end else if (fall) begin
            if (mack) begin
              tx  <= mem_rdata;
              cnt <= 4'd0;
              st  <= S_RD;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_o    = 1'b0;
  assign sda_oe   = (st == S_ACKA) | (st == S_ACKH) | (st == S_ACKL) | ((st == S_RD) & ~tx[7]);
  assign mem_addr = ptr;

  // R10
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && $past(scl_s)) |-> $stable(sda_oe));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE));

  // R3
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && fall && cnt == 4'd8 && rx[7:1] != DEV_ADDR) |=> !sda_oe);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && fall && cnt == 4'd7) |=> (ptr == $past(ptr) + 1'b1));

  // R9
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && fall && !mack) |=> (st == S_IDLE && !sda_oe));
endmodule

// File: tb/i2c_mem_reader_tb.sv
module i2c_mem_reader_tb;
  localparam int DEPTH = 512;
  localparam int AW = $clog2(DEPTH);
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_o, sda_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata;
  wire sda_bus = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int p = 0;
  bit quiet = 1'b0;
  int quiet_viol = 0;
  int edge_viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;

  always #10 clk = ~clk;

  i2c_mem_reader #(.DEPTH(DEPTH), .DEV_ADDR(7'h57)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input int a);
    return 8'((a * 29 + (a >> 5) + 7) & 255);
  endfunction

  always @(posedge clk) mem_rdata <= memf(int'(mem_addr));

  always @(negedge clk) begin
    if (rst_n) begin
      if (quiet && sda_oe) quiet_viol++;
      if (prev_scl && m_scl && (prev_oe != sda_oe)) edge_viol++;
    end
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic bit_w(input bit b);
    m_sda = b; wq();
    m_scl = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bit_r(output bit b);
    m_sda = 1'b1; wq();
    m_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    b = sda_bus;
    repeat (Q - Q/2) @(negedge clk);
    m_scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(s);
    ack = ~s;
  endtask

  task automatic rbits(output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_r(s);
      d[i] = s;
    end
  endtask

  task automatic reads(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rbits(d);
      chk(d == memf(p), tag, d, memf(p));
      p = (p + 1) % DEPTH;
      bit_w(i == n - 1);
    end
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    bstart();
    wbyte(8'hAF, ack);
    chk(ack, "R3 read byte ack", ack, 1);
    reads(n, tag);
    bstop();
  endtask

  task automatic header(input logic [15:0] a);
    bit ack;
    bstart();
    wbyte(8'hAE, ack);
    chk(ack, "R3 write byte ack", ack, 1);
    wbyte(a[15:8], ack);
    chk(ack, "R4 high word ack", ack, 1);
    wbyte(a[7:0], ack);
    chk(ack, "R4 low word ack", ack, 1);
    p = int'(a) % DEPTH;
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    bit ack;
    header(a);
    bstart();
    wbyte(8'hAF, ack);
    chk(ack, "R5 read byte ack", ack, 1);
    reads(n, tag);
    bstop();
  endtask

  task automatic set_addr(input logic [15:0] a);
    header(a);
    bstop();
    wq();
    chk(int'(mem_addr) == p, "R6 mem_addr after set", int'(mem_addr), p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wq();
    // R1
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(int'(mem_addr) == 0, "R1 reset mem_addr", int'(mem_addr), 0);
    cur_read(2, "R1 R7 current read from reset");
    // R5 R8
    rand_read(16'h0123, 4, "R5 R8 random sequential");
    // R6
    set_addr(16'h0040);
    cur_read(1, "R6 current read after set");
    // R8 wrap
    rand_read(16'h01FE, 4, "R8 wrap read");
    // R4 upper bits ignored
    rand_read(16'hFE05, 1, "R4 truncated address");
    // R3 wrong device address
    bstart();
    wbyte(8'hA0, ack);
    chk(!ack, "R3 foreign byte nack", ack, 0);
    quiet = 1'b1;
    wbyte(8'hAF, ack);
    chk(!ack, "R2 ignored after mismatch", ack, 0);
    quiet = 1'b0;
    bstop();
    wbyte(8'hAE, ack);
    // R2 bits without start after stop
    m_scl = 1'b0; wq();
    quiet = 1'b1;
    wbyte(8'hAF, ack);
    chk(!ack, "R2 no ack without start", ack, 0);
    wbyte(8'hAE, ack);
    chk(!ack, "R2 no ack without start 2", ack, 0);
    quiet = 1'b0;
    bstop();
    cur_read(1, "R2 counter kept");
    // R9 nack ends read
    bstart();
    wbyte(8'hAF, ack);
    rbits(d);
    chk(d == memf(p), "R9 byte before nack", d, memf(p));
    p = (p + 1) % DEPTH;
    bit_w(1'b1);
    quiet = 1'b1;
    rbits(d);
    chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    quiet = 1'b0;
    bstop();
    // R9 stop inside ninth clock
    bstart();
    wbyte(8'hAF, ack);
    rbits(d);
    chk(d == memf(p), "R9 byte before ninth stop", d, memf(p));
    p = (p + 1) % DEPTH;
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
    m_scl = 1'b0; wq();
    quiet = 1'b1;
    rbits(d);
    chk(d == 8'hFF, "R9 released after ninth stop", d, 8'hFF);
    quiet = 1'b0;
    bstop();
    cur_read(2, "R7 R9 counter after ninth stop");
    // mixed random traffic
    for (int k = 0; k < 22; k++) begin
      int sel = int'($urandom_range(2, 0));
      logic [15:0] a = 16'($urandom());
      int n = int'($urandom_range(5, 1));
      if (sel == 0) rand_read(a, n, "R5 R8 random traffic");
      else if (sel == 1) begin
        set_addr(a);
        cur_read(n, "R6 random set then read");
      end else cur_read(n, "R7 random current read");
    end
    rand_read(16'h01FF, 3, "R8 last to first");
    // R10 R11
    chk(edge_viol == 0, "R10 sda_oe change while scl high", edge_viol, 0);
    chk(quiet_viol == 0, "R2 drive during ignored traffic", quiet_viol, 0);
    chk(sda_o == 1'b0, "R10 open drain output", sda_o, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule